// File: doc/BRIEF.md
# Double-Buffered Line Data Read Holder

This block keeps the five data bytes recovered from a broadcast data line ready for a read-only serial bus slave. A staging bank takes the bytes of every line that finishes without a decoding error. An output bank holds the bytes the bus actually reads. A fresh-data flag marks whether the output bank has been read since it was last filled. A good line is copied into the output bank at once, unless the bus is in a transaction with this device. In that case the copy is remembered and carried out at the next bus start or stop event, so a reader never sees the bytes change partway through a transaction.

Bytes leave on a valid/ready stream. `rd_valid` is high while the device is addressed. A byte is taken on every clock edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_data` and the read position hold steady, so the bus side can apply back-pressure for as long as it needs. The bus side raises `read_done` when a read finishes. If at least one byte has gone out since the last start event, the data counts as consumed. Until new good data arrives, every byte then reads as 0xFF.

The bit-level bus signalling and the line decoding are done elsewhere. This block only sees their event strobes, the addressed level and the staging bytes.

Top module: `linedata_read_buffer`

## Requirements
- R1: After reset the fresh flag is clear, every byte offered reads 0xFF, and `rd_valid` equals `addressed`.
- R2: A `line_done` pulse with `line_error` low, while `addressed` is low, loads `stage_data` into the output bank and sets the fresh flag on that edge.
- R3: A `line_done` pulse with `line_error` high changes neither the output bank nor the fresh flag, so the earlier data still reads back.
- R4: A good line that ends while `addressed` is high is not copied. It is copied on the first later edge with `bus_start` or `bus_stop` high, and until then reads return the previous contents.
- R5: If several good lines end while a copy is deferred, the copy that finally takes place uses the newest one.
- R6: `stage_data` byte lane k sits at bits [8k+7:8k]. Bytes go out in the order lane 1, 2, 3, 4, then lane 0. The position returns to the first byte on every `bus_start`. After the fifth byte, further bytes read 0xFF.
- R7: `read_done` clears the fresh flag only if at least one byte has been transferred since the last `bus_start`. With no byte transferred, it has no effect.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_data` and the read position stay unchanged.
- R9: While the fresh flag is clear, every byte reads 0xFF, until another good line has been copied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_done | input | 1 | One-cycle pulse: a data line has finished |
| line_error | input | 1 | Qualifies line_done: the line had a decoding error |
| stage_data | input | 40 | Bytes of the finished line, lane k at bits [8k+7:8k] |
| bus_start | input | 1 | One-cycle pulse: bus start event |
| bus_stop | input | 1 | One-cycle pulse: bus stop event |
| addressed | input | 1 | Level: device is selected in the current transaction |
| rd_valid | output | 1 | A byte is offered |
| rd_ready | input | 1 | Bus side takes the offered byte |
| rd_data | output | 8 | Offered byte |
| read_done | input | 1 | One-cycle pulse: the read transaction is complete |

## Verification
The bench applies the following patterns:
- **Good and errored lines, while idle.** This separates an accepted copy from a rejected one.
- **Good lines arriving inside a transaction.** These show whether the copy is deferred to the stop event rather than landing at once, and whether the newest staging data wins when two lines queue up.
- **Reads that complete with and without a byte transferred, plus repeated reads.** These tell a real consumption (bytes turn to 0xFF) from an empty one (data kept).
- **A repeated start and a long stall with `rd_ready` low.** These show that the read position restarts on a start event and freezes under back-pressure.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  // Delivery position p reads lane (p+1) mod n: lanes 1..n-1 first, lane 0 last.
  function automatic int unsigned lane_of(input int unsigned pos, input int unsigned n);
    return (pos + 1) % n;
  endfunction
endpackage

// File: rtl/lrb_copy_ctrl.sv
module lrb_copy_ctrl #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_done,
  input  logic         line_error,
  input  logic [W-1:0] stage_data,
  input  logic         addressed,
  input  logic         bus_start,
  input  logic         bus_stop,
  output logic         copy_now,
  output logic [W-1:0] copy_data,
  output logic         pend_q
);
  logic [W-1:0] stage_q;
  logic         ok_line;
  logic         bus_evt;

  assign ok_line   = line_done & ~line_error;
  assign bus_evt   = bus_start | bus_stop;
  // Copy at once when idle; otherwise only on a start/stop event.
  assign copy_now  = (ok_line & ~addressed) | ((ok_line | pend_q) & bus_evt);
  assign copy_data = ok_line ? stage_data : stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (ok_line) stage_q <= stage_data;
      if (copy_now)     pend_q <= 1'b0;
      else if (ok_line) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lrb_out_bank.sv
module lrb_out_bank #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         copy_now,
  input  logic [W-1:0] copy_data,
  input  logic         consume,
  output logic [W-1:0] bank_q,
  output logic         fresh_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (copy_now) bank_q <= copy_data;
      // A copy on the same edge as a consume leaves new data valid.
      if (copy_now)     fresh_q <= 1'b1;
      else if (consume) fresh_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lrb_byte_mux.sv
module lrb_byte_mux #(
  parameter int BYTES = 5,
  parameter int BW    = 8,
  localparam int W    = BYTES * BW,
  localparam int IW   = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  bank_q,
  input  logic          fresh_q,
  input  logic          addressed,
  input  logic          bus_start,
  input  logic          rd_ready,
  input  logic          read_done,
  output logic          rd_valid,
  output logic [BW-1:0] rd_data,
  output logic          consume,
  output logic [IW-1:0] idx_q,
  output logic          sent_q
);
  logic [BW-1:0] ordered [BYTES];
  logic          xfer;

  for (genvar p = 0; p < BYTES; p++) begin : g_order
    localparam int LANE = lrb_pkg::lane_of(p, BYTES);
    assign ordered[p] = bank_q[LANE*BW +: BW];
  end

  assign rd_valid = addressed;
  assign xfer     = rd_valid & rd_ready;
  assign consume  = read_done & sent_q;

  always_comb begin
    rd_data = '1;
    for (int p = 0; p < BYTES; p++) begin
      if (fresh_q && idx_q == IW'(p)) rd_data = ordered[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      sent_q <= 1'b0;
    end else if (bus_start) begin
      idx_q  <= '0;
      sent_q <= 1'b0;
    end else if (xfer) begin
      sent_q <= 1'b1;
      if (idx_q < IW'(BYTES)) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/linedata_read_buffer.sv
module linedata_read_buffer #(
  parameter int BYTES = 5,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_done,
  input  logic                line_error,
  input  logic [BYTES*BW-1:0] stage_data,
  input  logic                bus_start,
  input  logic                bus_stop,
  input  logic                addressed,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [BW-1:0]       rd_data,
  input  logic                read_done
);
  localparam int W  = BYTES * BW;
  localparam int IW = $clog2(BYTES + 1);

  logic          copy_now;
  logic [W-1:0]  copy_data;
  logic          pend_q;
  logic [W-1:0]  bank_q;
  logic          fresh_q;
  logic          consume;
  logic [IW-1:0] idx_q;
  logic          sent_q;

  lrb_copy_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .line_done(line_done), .line_error(line_error),
    .stage_data(stage_data), .addressed(addressed), .bus_start(bus_start),
    .bus_stop(bus_stop), .copy_now(copy_now), .copy_data(copy_data), .pend_q(pend_q)
  );

  lrb_out_bank #(.W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .copy_now(copy_now), .copy_data(copy_data),
    .consume(consume), .bank_q(bank_q), .fresh_q(fresh_q)
  );

  lrb_byte_mux #(.BYTES(BYTES), .BW(BW)) u_mux (
    .clk(clk), .rst_n(rst_n), .bank_q(bank_q), .fresh_q(fresh_q),
    .addressed(addressed), .bus_start(bus_start), .rd_ready(rd_ready),
    .read_done(read_done), .rd_valid(rd_valid), .rd_data(rd_data),
    .consume(consume), .idx_q(idx_q), .sent_q(sent_q)
  );
endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
  parameter int BYTES = 5,
  parameter int BW    = 8,
  localparam int W    = BYTES * BW,
  localparam int IW   = $clog2(BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_done,
  input logic          line_error,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          addressed,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [BW-1:0] rd_data,
  input logic          read_done,
  input logic [W-1:0]  bank_q,
  input logic          fresh_q,
  input logic          pend_q,
  input logic [IW-1:0] idx_q,
  input logic          sent_q
);
  logic good_line;
  logic evt;
  assign good_line = line_done & ~line_error;
  assign evt       = bus_start | bus_stop;

  a_r2_copy_sets_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (good_line && !addressed) |=> fresh_q);

  a_r3_error_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && line_error && !evt) |=> ($stable(bank_q) && $stable(fresh_q)));

  a_r4_no_copy_while_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    (addressed && !evt) |=> $stable(bank_q));

  a_r4_defer_remembered: assert property (@(posedge clk) disable iff (!rst_n)
    (good_line && addressed && !evt) |=> pend_q);

  a_r7_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && sent_q && !(good_line && !addressed) && !(evt && (pend_q || good_line)))
      |=> !fresh_q);

  a_r9_empty_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh_q |-> (rd_data == '1));

  a_r6_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(BYTES));

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !bus_start) |=> $stable(idx_q));
endmodule

bind linedata_read_buffer lrb_checker #(.BYTES(BYTES), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_done(line_done), .line_error(line_error),
  .bus_start(bus_start), .bus_stop(bus_stop), .addressed(addressed),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .read_done(read_done),
  .bank_q(bank_q), .fresh_q(fresh_q), .pend_q(pend_q), .idx_q(idx_q), .sent_q(sent_q)
);

// File: tb/linedata_read_buffer_bench.sv
module linedata_read_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_done = 1'b0, line_error = 1'b0;
  logic [39:0] stage_data = '0;
  logic        bus_start = 1'b0, bus_stop = 1'b0, addressed = 1'b0;
  logic        rd_valid, rd_ready = 1'b0, read_done = 1'b0;
  logic [7:0]  rd_data;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  linedata_read_buffer u_linedata_read_buffer (
    .clk(clk), .rst_n(rst_n), .line_done(line_done), .line_error(line_error),
    .stage_data(stage_data), .bus_start(bus_start), .bus_stop(bus_stop),
    .addressed(addressed), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .read_done(read_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_line(input logic [39:0] d, input bit err);
    @(negedge clk); line_done = 1'b1; line_error = err; stage_data = d;
    @(negedge clk); line_done = 1'b0; line_error = 1'b0;
  endtask

  task automatic begin_read();
    @(negedge clk); addressed = 1'b1; bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic end_read(input bit done);
    if (done) begin
      @(negedge clk); read_done = 1'b1;
      @(negedge clk); read_done = 1'b0;
    end
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0; addressed = 1'b0;
  endtask

  task automatic pull(output logic [7:0] b);
    @(negedge clk); rd_ready = 1'b1; #1 b = rd_data;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  // Expect the five bytes of d in order lane 1,2,3,4,0 (R6).
  task automatic expect_all(input logic [39:0] d, input string tag);
    logic [7:0] b;
    for (int p = 0; p < 5; p++) begin
      pull(b);
      chk(b == d[((p + 1) % 5) * 8 +: 8], tag, b, d[((p + 1) % 5) * 8 +: 8]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] b;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 valid low when not addressed", rd_valid, 0);
    begin_read();
    chk(rd_valid == 1'b1, "R1 valid follows addressed", rd_valid, 1);
    pull(b);
    chk(b == 8'hFF, "R1 empty after reset", b, 8'hFF);
    end_read(1'b1);
  endtask

  task automatic t_good_line();
    logic [7:0] b;
    send_line(40'hA5_44_33_22_11, 1'b0);
    begin_read();
    expect_all(40'hA5_44_33_22_11, "R2/R6 order");
    pull(b);
    chk(b == 8'hFF, "R6 beyond fifth byte", b, 8'hFF);
    end_read(1'b1);
    begin_read();
    pull(b);
    chk(b == 8'hFF, "R7/R9 consumed reads ones", b, 8'hFF);
    end_read(1'b1);
  endtask

  task automatic t_error_line();
    send_line(40'h15_14_13_12_11, 1'b0);
    send_line(40'hEE_EE_EE_EE_EE, 1'b1);
    begin_read();
    expect_all(40'h15_14_13_12_11, "R3 errored line ignored");
    end_read(1'b1);
  endtask

  task automatic t_defer();
    logic [7:0] b;
    send_line(40'h35_34_33_32_31, 1'b0);
    begin_read();
    send_line(40'h45_44_43_42_41, 1'b0);
    expect_all(40'h35_34_33_32_31, "R4 copy deferred");
    end_read(1'b1);
    begin_read();
    expect_all(40'h45_44_43_42_41, "R4 copy at stop");
    end_read(1'b1);
    begin_read();
    send_line(40'h55_54_53_52_51, 1'b0);
    send_line(40'h65_64_63_62_61, 1'b0);
    pull(b);
    chk(b == 8'hFF, "R4/R9 no copy mid-read", b, 8'hFF);
    end_read(1'b1);
    begin_read();
    expect_all(40'h65_64_63_62_61, "R5 newest line wins");
    end_read(1'b1);
  endtask

  task automatic t_empty_done();
    send_line(40'h75_74_73_72_71, 1'b0);
    begin_read();
    end_read(1'b1);
    begin_read();
    expect_all(40'h75_74_73_72_71, "R7 done without byte kept data");
    end_read(1'b1);
  endtask

  task automatic t_restart_and_stall();
    logic [7:0] b;
    send_line(40'h85_84_83_82_81, 1'b0);
    begin_read();
    pull(b);
    pull(b);
    chk(b == 8'h83, "R6 second byte", b, 8'h83);
    begin_read();
    pull(b);
    chk(b == 8'h82, "R6 restart on start", b, 8'h82);
    @(negedge clk); #1;
    chk(rd_data == 8'h83, "R8 offered byte", rd_data, 8'h83);
    repeat (3) @(negedge clk);
    #1 chk(rd_data == 8'h83 && rd_valid, "R8 held under stall", rd_data, 8'h83);
    pull(b);
    chk(b == 8'h83, "R8 position held", b, 8'h83);
    end_read(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_good_line();
    t_error_line();
    t_defer();
    t_empty_done();
    t_restart_and_stall();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule